// File: doc/BRIEF.md
# Video RAM transfer-cycle controller

This block is a synthesizable behavioural model of the transfer side of a dual-port video memory. It holds a word-organised array of rows and one serial register that is as wide as a row. The serial register has a pointer and a direction, input or output. All strobes are sampled on a single system clock `clk`, and their edges are found by comparing each sample with the one before. When the row strobe falls, the block latches the transfer-control, write-enable, serial-enable and special-function levels, together with the row address. When the column strobe then falls, the block performs the decoded transfer. It can copy a whole row from the register into the array, copy a whole row or half a row from the array into the register, or only change the serial direction. The same column-strobe edge can also load the serial pointer from the address bus.

Between transfers, a host clocks words through the serial port with `sclk`. In output mode each rising edge presents the word at the pointer on `sdo`. In input mode each rising edge stores `sdi` at the pointer. In both modes the pointer then steps up by one and wraps at the end of the register. The array size and the word width are parameters. The defaults are 16 rows of 16 four-bit words, a reduced version of the full 512 by 512 organisation.

Top module: `vram_xfer_ctrl`

## Requirements
- R1: A transfer is recognised only when `xfer_n` is low and `col_stb_n` is high in the clock cycle where `row_stb_n` is first seen low. Any other row-strobe fall leaves the array, the serial register, the pointer and `sin_mode` unchanged.
- R2: The row address is `addr[ROW_BITS-1:0]` sampled at the row-strobe fall. The tap is `addr[COL_BITS-1:0]` sampled at the first column-strobe fall inside the same row-strobe low period. Only that first column-strobe fall acts.
- R3: Normal write (`we_n`=0, `spec_fn`=0, `ser_en_n`=0) copies every serial-register word into the addressed row, loads the pointer with the tap and sets `sin_mode`=1.
- R4: Alternate write (`we_n`=0, `spec_fn`=1, either level of `ser_en_n`) behaves exactly like a normal write.
- R5: Pseudo write (`we_n`=0, `spec_fn`=0, `ser_en_n`=1) changes no array row, ignores the row address, loads the pointer with the tap and sets `sin_mode`=1.
- R6: Normal read (`we_n`=1, `spec_fn`=0) copies the addressed row into the serial register, loads the pointer with the tap and sets `sin_mode`=0.
- R7: Split read (`we_n`=1, `spec_fn`=1) copies only the half of the row opposite to the pointer's top bit, where word indices below COLS/2 form the lower half. It keeps the other half of the register and the pointer unchanged, and sets `sin_mode`=0.
- R8: In a clock cycle where `sclk` is first seen high, output mode registers the word at the pointer onto `sdo`, and input mode writes `sdi` into the word at the pointer. In both modes the pointer then increments. `sdo` changes at no other time.
- R9: The pointer wraps from COLS-1 to 0.
- R10: A synchronous active-low reset sets `sin_mode`=0, `sdo`=0 and the pointer to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| xfer_n | input | 1 | Active-low transfer-cycle select |
| we_n | input | 1 | Low selects a write-direction transfer |
| ser_en_n | input | 1 | Serial-enable level, used to tell normal from pseudo write |
| spec_fn | input | 1 | Special-function level: alternate write or split read |
| addr | input | ADDR_W | Row address at the row-strobe fall, tap at the column-strobe fall |
| sclk | input | 1 | Serial clock; rising edges step the serial port |
| sdi | input | DATA_W | Serial input word |
| sdo | output | DATA_W | Serial output word, registered |
| sin_mode | output | 1 | 1 = serial input mode, 0 = serial output mode |

## Verification
On every cycle, the assertions check how the pointer behaves: it steps and wraps on each serial edge, and it stays put through a split read. They also check that `sdo` holds between output edges, that the serial direction is correct after each transfer kind, and that a non-transfer row-strobe fall leaves nothing pending. The bench scenarios cover what the assertions cannot: the actual row contents moved in each direction for every row, with the tap varied across the register. They also show that a pseudo write or an ignored cycle leaves array rows intact, and that a split read replaces the correct half of the register.

// File: rtl/vram_pkg.sv
// Package: shared transfer-kind encoding for the video RAM transfer controller.
// Assumes: one transfer kind is active at a time; XF_NONE means no pending transfer.
package vram_pkg;
    typedef enum logic [2:0] {
        XF_NONE      = 3'd0,
        XF_WR_NORM   = 3'd1,
        XF_WR_ALT    = 3'd2,
        XF_WR_PSEUDO = 3'd3,
        XF_RD_NORM   = 3'd4,
        XF_RD_SPLIT  = 3'd5
    } xfer_e;
endpackage

// File: rtl/vram_edge_det.sv
// Module: single-signal edge detector on the system clock.
// Reports one selected edge (falling or rising) in the cycle the new level is first sampled.
// Assumes: the input is already synchronous to clk; IDLE is its level while in reset.
module vram_edge_det #(
    parameter bit FALLING = 1'b1,
    parameter bit IDLE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic hit
);
    logic lvl_q;

    // Remember the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= IDLE;
        else        lvl_q <= lvl;
    end

    generate
        if (FALLING) begin : g_fall
            assign hit = lvl_q & ~lvl;
        end else begin : g_rise
            assign hit = ~lvl_q & lvl;
        end
    endgenerate
endmodule

// File: rtl/vram_xfer_decode.sv
// Module: combinational transfer-kind decoder.
// Maps the control levels present at a row-strobe fall to a transfer kind.
// Assumes: the caller only uses the result in the row-strobe-fall cycle.
module vram_xfer_decode
    import vram_pkg::*;
(
    input  logic  xfer_n,
    input  logic  col_stb_n,
    input  logic  we_n,
    input  logic  ser_en_n,
    input  logic  spec_fn,
    output xfer_e kind
);
    // Priority decode: non-transfer first, then direction, then variant.
    always_comb begin
        if (xfer_n || !col_stb_n)  kind = XF_NONE;
        else if (!we_n) begin
            if (spec_fn)           kind = XF_WR_ALT;
            else if (ser_en_n)     kind = XF_WR_PSEUDO;
            else                   kind = XF_WR_NORM;
        end else begin
            if (spec_fn)           kind = XF_RD_SPLIT;
            else                   kind = XF_RD_NORM;
        end
    end
endmodule

// File: rtl/vram_array.sv
// Module: row-organised storage array with whole-row write and combinational whole-row read.
// Assumes: a single row index serves both read and write; contents are not reset.
module vram_array #(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 4
) (
    input  logic                 clk,
    input  logic                 wr_en,
    input  logic [ROW_BITS-1:0]  row,
    input  logic [ROW_W-1:0]     wr_data,
    output logic [ROW_W-1:0]     rd_data
);
    localparam int ROWS  = 1 << ROW_BITS;
    localparam int ROW_W = (1 << COL_BITS) * DATA_W;

    logic [ROW_W-1:0] mem [ROWS];

    // Store a complete row when a register-to-array transfer fires.
    always_ff @(posedge clk) begin
        if (wr_en) mem[row] <= wr_data;
    end

    assign rd_data = mem[row];
endmodule

// File: rtl/vram_sam.sv
// Module: serial access register with pointer and direction.
// Loads whole or half rows on a transfer, and steps words in or out on serial edges.
// Assumes: a transfer and a serial edge in the same cycle give priority to the transfer.
module vram_sam #(
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_go,
    input  logic                 ld_full,
    input  logic                 ld_half,
    input  logic                 tap_ld,
    input  logic [COL_BITS-1:0]  tap,
    input  logic                 mode_in,
    input  logic [ROW_W-1:0]     row_in,
    input  logic                 sc_rise,
    input  logic [DATA_W-1:0]    sdi,
    output logic [ROW_W-1:0]     row_out,
    output logic [DATA_W-1:0]    sdo,
    output logic                 sin_mode
);
    localparam int COLS  = 1 << COL_BITS;
    localparam int HALF  = COLS / 2;
    localparam int ROW_W = COLS * DATA_W;
    typedef logic [COL_BITS-1:0] ptr_t;
    localparam ptr_t LAST = ptr_t'(COLS - 1);

    logic [DATA_W-1:0] word [COLS];
    ptr_t              ptr;
    logic              ser_step;

    assign ser_step = sc_rise && !xfer_go;

    // Update register words from a row load or from serial input.
    always_ff @(posedge clk) begin
        for (int c = 0; c < COLS; c++) begin
            if (ld_full)
                word[c] <= row_in[c*DATA_W +: DATA_W];
            else if (ld_half && ((c >= HALF) != ptr[COL_BITS-1]))
                word[c] <= row_in[c*DATA_W +: DATA_W];
            else if (ser_step && sin_mode && (ptr == ptr_t'(c)))
                word[c] <= sdi;
        end
    end

    // Pointer, direction and output word control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr      <= '0;
            sin_mode <= 1'b0;
            sdo      <= '0;
        end else if (xfer_go) begin
            sin_mode <= mode_in;
            if (tap_ld) ptr <= tap;
        end else if (sc_rise) begin
            if (!sin_mode) sdo <= word[ptr];
            ptr <= ptr + 1'b1;
        end
    end

    generate
        for (genvar c = 0; c < COLS; c++) begin : g_pack
            assign row_out[c*DATA_W +: DATA_W] = word[c];
        end
    endgenerate

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ser_step |=> ptr == ptr_t'($past(ptr) + 1'b1)); // R8
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_step && ptr == LAST) |=> ptr == '0); // R9
    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(ser_step && !sin_mode) |=> $stable(sdo)); // R8
    AST_SPLIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_go && ld_half) |=> $stable(ptr)); // R7
    AST_RESET_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ptr == '0 && sdo == '0 && !sin_mode)); // R10
endmodule

// File: rtl/vram_xfer_ctrl.sv
// Module: top of the video RAM transfer controller.
// Latches the control levels and the row address at the row-strobe fall, then runs the
// decoded transfer at the first column-strobe fall while the row strobe stays low.
// Assumes: every strobe is synchronous to clk and idles inactive during reset.
module vram_xfer_ctrl
    import vram_pkg::*;
#(
    parameter int ROW_BITS = 4,
    parameter int COL_BITS = 4,
    parameter int DATA_W   = 4,
    localparam int ADDR_W  = (ROW_BITS > COL_BITS) ? ROW_BITS : COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              xfer_n,
    input  logic              we_n,
    input  logic              ser_en_n,
    input  logic              spec_fn,
    input  logic [ADDR_W-1:0] addr,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sdi,
    output logic [DATA_W-1:0] sdo,
    output logic              sin_mode
);
    localparam int ROW_W = (1 << COL_BITS) * DATA_W;

    logic                ras_fall, cas_fall, sc_rise;
    xfer_e               kind_now, kind_q;
    logic [ROW_BITS-1:0] row_q;
    logic                go, is_wr, arr_we, ld_full, ld_half, tap_ld;
    logic [ROW_W-1:0]    arr_rd, sam_row;

    vram_edge_det #(.FALLING(1'b1), .IDLE(1'b1)) u_ras (
        .clk(clk), .rst_n(rst_n), .lvl(row_stb_n), .hit(ras_fall));
    vram_edge_det #(.FALLING(1'b1), .IDLE(1'b1)) u_cas (
        .clk(clk), .rst_n(rst_n), .lvl(col_stb_n), .hit(cas_fall));
    vram_edge_det #(.FALLING(1'b0), .IDLE(1'b0)) u_sc (
        .clk(clk), .rst_n(rst_n), .lvl(sclk), .hit(sc_rise));

    vram_xfer_decode u_dec (
        .xfer_n(xfer_n), .col_stb_n(col_stb_n), .we_n(we_n),
        .ser_en_n(ser_en_n), .spec_fn(spec_fn), .kind(kind_now));

    // Hold the pending transfer from the row-strobe fall until it fires or the strobe rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= XF_NONE;
            row_q  <= '0;
        end else if (ras_fall) begin
            kind_q <= kind_now;
            row_q  <= addr[ROW_BITS-1:0];
        end else if (row_stb_n || go) begin
            kind_q <= XF_NONE;
        end
    end

    // Turn the pending kind into one-cycle actions at the column-strobe fall.
    always_comb begin
        go      = cas_fall && !row_stb_n && (kind_q != XF_NONE);
        is_wr   = (kind_q == XF_WR_NORM) || (kind_q == XF_WR_ALT) || (kind_q == XF_WR_PSEUDO);
        arr_we  = go && ((kind_q == XF_WR_NORM) || (kind_q == XF_WR_ALT));
        ld_full = go && (kind_q == XF_RD_NORM);
        ld_half = go && (kind_q == XF_RD_SPLIT);
        tap_ld  = go && (kind_q != XF_RD_SPLIT);
    end

    vram_array #(.ROW_BITS(ROW_BITS), .COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .wr_en(arr_we), .row(row_q), .wr_data(sam_row), .rd_data(arr_rd));

    vram_sam #(.COL_BITS(COL_BITS), .DATA_W(DATA_W)) u_sam (
        .clk(clk), .rst_n(rst_n), .xfer_go(go), .ld_full(ld_full), .ld_half(ld_half),
        .tap_ld(tap_ld), .tap(addr[COL_BITS-1:0]), .mode_in(is_wr), .row_in(arr_rd),
        .sc_rise(sc_rise), .sdi(sdi), .row_out(sam_row), .sdo(sdo), .sin_mode(sin_mode));

    AST_IGNORED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_fall && (xfer_n || !col_stb_n)) |=> kind_q == XF_NONE); // R1
    AST_WR_TO_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && is_wr) |=> sin_mode); // R3
    AST_RD_TO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !is_wr) |=> !sin_mode); // R6
    AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> kind_q == XF_NONE); // R2
endmodule

// File: tb/sim_vram_xfer_ctrl.sv
module sim_vram_xfer_ctrl;
    localparam int RB = 4, CB = 4, DW = 4;
    localparam int ROWS = 1 << RB, COLS = 1 << CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic row_stb_n = 1'b1, col_stb_n = 1'b1, xfer_n = 1'b1;
    logic we_n = 1'b1, ser_en_n = 1'b0, spec_fn = 1'b0, sclk = 1'b0;
    logic [CB-1:0] addr = '0;
    logic [DW-1:0] sdi = '0;
    logic [DW-1:0] sdo;
    logic sin_mode;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vram_xfer_ctrl #(.ROW_BITS(RB), .COL_BITS(CB), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .xfer_n(xfer_n), .we_n(we_n), .ser_en_n(ser_en_n), .spec_fn(spec_fn),
        .addr(addr), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sin_mode(sin_mode));

    function automatic logic [DW-1:0] pat(input int r, input int c);
        return DW'((r * 7 + c * 3 + 1) % (1 << DW));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_xfer(input logic xn, input logic we, input logic sp, input logic se,
                           input int row, input int tap, input bit cas_early);
        @(negedge clk);
        addr = CB'(row); xfer_n = xn; we_n = we; spec_fn = sp; ser_en_n = se;
        if (cas_early) col_stb_n = 1'b0;
        @(negedge clk); row_stb_n = 1'b0;
        @(negedge clk); col_stb_n = 1'b1; addr = CB'(tap);
        @(negedge clk); col_stb_n = 1'b0;
        @(negedge clk); addr = CB'(row + 5);   // second column fall below must not act
        col_stb_n = 1'b1;
        @(negedge clk); col_stb_n = 1'b0;
        @(negedge clk);
        row_stb_n = 1'b1; col_stb_n = 1'b1; xfer_n = 1'b1;
        we_n = 1'b1; spec_fn = 1'b0; ser_en_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic sc_in(input logic [DW-1:0] d);
        sdi = d; sclk = 1'b1;
        @(negedge clk); sclk = 1'b0;
        @(negedge clk);
    endtask

    task automatic sc_out(input string req, input logic [DW-1:0] exp);
        sclk = 1'b1;
        @(negedge clk);
        chk(req, int'(sdo), int'(exp));
        sclk = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 sdo after reset", int'(sdo), 0);
        chk("R10 sin_mode after reset", int'(sin_mode), 0);

        // Load every row: pseudo write sets tap r, fill with wrap, then a write-transfer variant.
        for (int r = 0; r < ROWS; r++) begin
            do_xfer(1'b0, 1'b0, 1'b0, 1'b1, (r + 3) % ROWS, r % COLS, 1'b0);
            chk("R5 pseudo write selects input mode", int'(sin_mode), 1);
            for (int i = 0; i < COLS; i++) sc_in(pat(r, (r + i) % COLS));
            case (r % 3)
                0: do_xfer(1'b0, 1'b0, 1'b0, 1'b0, r, 0, 1'b0);
                1: do_xfer(1'b0, 1'b0, 1'b1, 1'b0, r, 0, 1'b0);
                default: do_xfer(1'b0, 1'b0, 1'b1, 1'b1, r, 0, 1'b0);
            endcase
            chk(r % 3 == 0 ? "R3 write leaves input mode" : "R4 alternate write input mode",
                int'(sin_mode), 1);
        end

        // Read every row back with a row-dependent tap; wrap exercised.
        for (int r = 0; r < ROWS; r++) begin
            int tap;
            tap = (r * 5) % COLS;
            do_xfer(1'b0, 1'b1, 1'b0, 1'b0, r, tap, 1'b0);
            chk("R6 read selects output mode", int'(sin_mode), 0);
            for (int i = 0; i < COLS; i++)
                sc_out(r % 3 == 0 ? "R3 R6 R2 R9 row data" :
                       (r % 3 == 1 ? "R4 R6 R9 row data sen low" : "R4 R8 row data sen high"),
                       pat(r, (tap + i) % COLS));
        end

        // Ignored cycles: transfer select high, then column strobe low at row fall.
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 2, 0, 1'b0);
        do_xfer(1'b1, 1'b0, 1'b0, 1'b0, 9, 0, 1'b0);
        chk("R1 xfer_n high keeps output mode", int'(sin_mode), 0);
        do_xfer(1'b0, 1'b0, 1'b0, 1'b0, 10, 0, 1'b1);
        chk("R1 column-first keeps output mode", int'(sin_mode), 0);
        for (int i = 0; i < COLS; i++) sc_out("R1 register untouched", pat(2, i));
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 9, 0, 1'b0);
        for (int i = 0; i < COLS; i++) sc_out("R1 row 9 not written", pat(9, i));
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 10, 0, 1'b0);
        for (int i = 0; i < COLS; i++) sc_out("R1 row 10 not written", pat(10, i));

        // Pseudo write must not store the register (holding row 2) into row 5.
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 2, 0, 1'b0);
        do_xfer(1'b0, 1'b0, 1'b0, 1'b1, 5, 0, 1'b0);
        chk("R5 pseudo write input mode", int'(sin_mode), 1);
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 5, 0, 1'b0);
        for (int i = 0; i < COLS; i++) sc_out("R5 row 5 unchanged", pat(5, i));

        // Split read with the pointer in the lower half: upper half replaced.
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3, 0, 1'b0);
        do_xfer(1'b0, 1'b1, 1'b1, 1'b0, 12, 6, 1'b0);
        chk("R7 split read output mode", int'(sin_mode), 0);
        for (int i = 0; i < COLS; i++)
            sc_out("R7 split lower pointer", (i < COLS / 2) ? pat(3, i) : pat(12, i));

        // Split read with the pointer in the upper half: lower half replaced.
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 3, COLS / 2, 1'b0);
        do_xfer(1'b0, 1'b1, 1'b1, 1'b0, 12, 1, 1'b0);
        for (int i = 0; i < COLS; i++) begin
            int c;
            c = (COLS / 2 + i) % COLS;
            sc_out("R7 R9 split upper pointer", (c >= COLS / 2) ? pat(3, c) : pat(12, c));
        end

        // Input mode must not move sdo.
        do_xfer(1'b0, 1'b1, 1'b0, 1'b0, 0, COLS - 1, 1'b0);
        sc_out("R9 last word before wrap", pat(0, COLS - 1));
        do_xfer(1'b0, 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
        sc_in(4'hF);
        chk("R8 sdo held in input mode", int'(sdo), int'(pat(0, COLS - 1)));

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule